// File: doc/BRIEF.md
# Program Counter with Two-Level Return Stack

This block holds the 10-bit instruction address of a small 8-bit controller core and works out the next address every clock. The next address depends on what the current instruction does. It can be a plain fetch, a skip, a write to the PC register, a short jump, a short call, a long jump, a long call, or a return. Bits [7:0], bit 8 and bit 9 of the address each take their next value from their own source: the instruction address field, the ALU result byte, a page bit taken from the status register, or the return stack.

The decoder in front of the block sends one operation code per cycle, together with the instruction address field, the ALU result and the page bit. A call saves the address of the following instruction on a two-entry return stack, and a return restores it. The stack never stops the core. A push onto a full stack drops the oldest entry and raises an overflow pulse. A pop from an empty stack returns the most recently popped address and raises an underflow pulse.

Top module: `pc_stack`

## Requirements
- R1: While `rst_ni` is low and after it is released, `pc_o` is 0x3FF (every bit set), `ovf_o` and `udf_o` are 0, and the return stack is empty.
- R2: Op 1 (next) loads `pc_o + 1`. Op 2 (skip) loads `pc_o + 2`. Both wrap modulo 1024.
- R3: Op 3 (PC write) loads `{1'b0, page_i, alu_i}`.
- R4: Op 4 (short jump) loads `{addr_i[9], page_i, addr_i[7:0]}`. Op 5 (short call) loads `{1'b0, page_i, addr_i[7:0]}`.
- R5: Op 6 (long jump) and op 7 (long call) load all of `addr_i[9:0]`.
- R6: Ops 5 and 7 push `pc_o + 1` (mod 1024) onto the return stack. Op 8 (return) loads the entry on top of the stack and removes it.
- R7: The stack is last-in first-out over two levels. Two nested calls return in reverse order.
- R8: A push while two entries are held drops the oldest entry. `ovf_o` is 1 for exactly the cycle that follows that push and is 0 at all other times.
- R9: A return while the stack is empty loads the most recently popped address (0 if nothing has been popped since reset) and leaves the stack empty. `udf_o` is 1 for exactly the cycle that follows that return and is 0 at all other times.
- R10: Op 0 (hold) and the unused codes 9 to 15 leave `pc_o` and the stack contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Control-flow operation for this cycle |
| addr_i | input | 10 | Address field from the instruction word |
| alu_i | input | 8 | ALU result byte, used by a PC write |
| page_i | input | 1 | Page bit from the status register |
| pc_o | output | 10 | Current instruction address |
| ovf_o | output | 1 | Pulse: a push dropped the oldest stack entry |
| udf_o | output | 1 | Pulse: a return found the stack empty |

## Verification
A wrong next-address selection shows on `pc_o` one cycle after the operation that caused it. Corrupted stack contents stay hidden until a later return, so the bench checks a return after every pattern of nesting depth, including a third nested call and returns taken on an empty stack. A wrong occupancy count shows in two ways: an overflow or underflow pulse that comes too early or too late, and a return that loads the wrong address. The reference model is compared against every port on every clock, so a mismatch is reported in the cycle it first reaches the ports.

// File: rtl/pc_stack_pkg.sv
package pc_stack_pkg;
  typedef enum logic [3:0] {
    OP_HOLD  = 4'd0,
    OP_NEXT  = 4'd1,
    OP_SKIP  = 4'd2,
    OP_WRPC  = 4'd3,
    OP_JMP   = 4'd4,
    OP_CALL  = 4'd5,
    OP_LJMP  = 4'd6,
    OP_LCALL = 4'd7,
    OP_RET   = 4'd8
  } pc_op_e;

  typedef enum logic [2:0] {
    SRC_KEEP,
    SRC_INC,
    SRC_ALU,
    SRC_SHORT,
    SRC_LONG,
    SRC_STACK
  } pc_src_e;
endpackage

// File: rtl/pc_stack_next.sv
module pc_stack_next
  import pc_stack_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [3:0]    op_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-3:0] alu_i,
  input  logic          page_i,
  input  logic [AW-1:0] top_i,
  output logic [AW-1:0] pc_nxt_o,
  output logic          push_o,
  output logic          pop_o,
  output logic [AW-1:0] ret_addr_o
);
  localparam int LW = AW - 2;

  pc_src_e       src;
  logic [AW-1:0] step;
  logic          hi_bit;
  logic [AW-1:0] inc_val;

  // decode the operation into an address source
  always_comb begin
    src    = SRC_KEEP;
    step   = AW'(1);
    hi_bit = 1'b0;
    push_o = 1'b0;
    pop_o  = 1'b0;
    unique case (op_i)
      OP_NEXT:  src = SRC_INC;
      OP_SKIP:  begin src = SRC_INC; step = AW'(2); end
      OP_WRPC:  src = SRC_ALU;
      OP_JMP:   begin src = SRC_SHORT; hi_bit = addr_i[AW-1]; end
      OP_CALL:  begin src = SRC_SHORT; push_o = 1'b1; end
      OP_LJMP:  src = SRC_LONG;
      OP_LCALL: begin src = SRC_LONG; push_o = 1'b1; end
      OP_RET:   begin src = SRC_STACK; pop_o = 1'b1; end
      default:  src = SRC_KEEP;
    endcase
  end

  assign inc_val    = pc_i + step;
  assign ret_addr_o = pc_i + AW'(1);

  // A[AW-1], A[AW-2] and A[LW-1:0] each pick their own source
  always_comb begin
    unique case (src)
      SRC_INC:   pc_nxt_o = inc_val;
      SRC_ALU:   pc_nxt_o = {1'b0, page_i, alu_i};
      SRC_SHORT: pc_nxt_o = {hi_bit, page_i, addr_i[LW-1:0]};
      SRC_LONG:  pc_nxt_o = addr_i;
      SRC_STACK: pc_nxt_o = top_i;
      default:   pc_nxt_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pc_stack_lifo.sv
module pc_stack_lifo #(
  parameter int AW    = 10,
  parameter int DEPTH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] din_i,
  output logic [AW-1:0] top_o,
  output logic          ovf_o,
  output logic          udf_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] slot_q [DEPTH];
  logic [CW-1:0] cnt_q;
  logic          full;
  logic          empty;
  logic          shift_up;

  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  // keep the last popped value in the top slot once the stack drains
  assign shift_up = pop_i && (cnt_q > CW'(1));

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == 0) begin : g_top
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       slot_q[i] <= '0;
        else if (push_i)   slot_q[i] <= din_i;
        else if (shift_up) slot_q[i] <= slot_q[i+1];
      end
    end else if (i == DEPTH - 1) begin : g_bottom
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     slot_q[i] <= '0;
        else if (push_i) slot_q[i] <= slot_q[i-1];
      end
    end else begin : g_mid
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       slot_q[i] <= '0;
        else if (push_i)   slot_q[i] <= slot_q[i-1];
        else if (shift_up) slot_q[i] <= slot_q[i+1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
      udf_o <= 1'b0;
    end else begin
      ovf_o <= push_i && full;
      udf_o <= pop_i && empty;
      if (push_i && !full)      cnt_q <= cnt_q + CW'(1);
      else if (pop_i && !empty) cnt_q <= cnt_q - CW'(1);
    end
  end

  assign top_o = slot_q[0];
endmodule

// File: rtl/pc_stack.sv
module pc_stack #(
  parameter int          AW     = 10,
  parameter int          DEPTH  = 2,
  parameter logic [AW-1:0] RST_PC = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [3:0]    op_i,
  input  logic [9:0]    addr_i,
  input  logic [7:0]    alu_i,
  input  logic          page_i,
  output logic [9:0]    pc_o,
  output logic          ovf_o,
  output logic          udf_o
);
  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_nxt;
  logic [AW-1:0] top;
  logic [AW-1:0] ret_addr;
  logic          push;
  logic          pop;

  pc_stack_next #(.AW(AW)) u_next (
    .op_i      (op_i),
    .pc_i      (pc_q),
    .addr_i    (addr_i),
    .alu_i     (alu_i),
    .page_i    (page_i),
    .top_i     (top),
    .pc_nxt_o  (pc_nxt),
    .push_o    (push),
    .pop_o     (pop),
    .ret_addr_o(ret_addr)
  );

  pc_stack_lifo #(.AW(AW), .DEPTH(DEPTH)) u_lifo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(push),
    .pop_i (pop),
    .din_i (ret_addr),
    .top_o (top),
    .ovf_o (ovf_o),
    .udf_o (udf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= RST_PC;
    else         pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pc_stack_checker.sv
module pc_stack_checker
  import pc_stack_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [3:0] op_i,
  input logic [9:0] addr_i,
  input logic [7:0] alu_i,
  input logic       page_i,
  input logic [9:0] pc_o,
  input logic       ovf_o,
  input logic       udf_o
);
  p_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_NEXT |=> pc_o == $past(pc_o) + 10'd1);

  p_skip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_SKIP |=> pc_o == $past(pc_o) + 10'd2);

  p_wrpc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_WRPC |=> pc_o == {1'b0, $past(page_i), $past(alu_i)});

  p_call_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_CALL |=> (pc_o[9] == 1'b0 && pc_o[7:0] == $past(addr_i[7:0])));

  p_long_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LJMP || op_i == OP_LCALL) |=> pc_o == $past(addr_i));

  p_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_o, udf_o}));

  p_ovf_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> ($past(op_i) == OP_CALL || $past(op_i) == OP_LCALL));

  p_udf_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_o |-> $past(op_i) == OP_RET);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HOLD || op_i > OP_RET) |=> $stable(pc_o));
endmodule

bind pc_stack pc_stack_checker u_checker (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .op_i  (op_i),
  .addr_i(addr_i),
  .alu_i (alu_i),
  .page_i(page_i),
  .pc_o  (pc_o),
  .ovf_o (ovf_o),
  .udf_o (udf_o)
);

// File: tb/pc_stack_test.sv
`timescale 1ns/1ps
module pc_stack_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [9:0] addr_i = '0;
  logic [7:0] alu_i = '0;
  logic       page_i = 1'b0;
  logic [9:0] pc_o;
  logic       ovf_o;
  logic       udf_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // reference state
  int unsigned m_pc;
  int unsigned m_stk[$];
  int unsigned m_last;
  bit          m_ovf;
  bit          m_udf;

  always #2 clk_i = ~clk_i;

  pc_stack uut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (op_i),
    .addr_i(addr_i),
    .alu_i (alu_i),
    .page_i(page_i),
    .pc_o  (pc_o),
    .ovf_o (ovf_o),
    .udf_o (udf_o)
  );

  task automatic compare(string tag);
    vectors++;
    if (pc_o !== m_pc[9:0] || ovf_o !== m_ovf || udf_o !== m_udf) begin
      errors++;
      $display("FAIL %s: pc=%h ovf=%b udf=%b expected pc=%h ovf=%b udf=%b",
               tag, pc_o, ovf_o, udf_o, m_pc[9:0], m_ovf, m_udf);
    end
  endtask

  task automatic model(input int op, input int addr, input int alu, input bit pg);
    int unsigned nxt;
    m_ovf = 0;
    m_udf = 0;
    nxt = m_pc;
    case (op)
      1: nxt = (m_pc + 1) % 1024;
      2: nxt = (m_pc + 2) % 1024;
      3: nxt = pg * 256 + alu;
      4: nxt = (addr & 512) + pg * 256 + (addr & 255);
      5: nxt = pg * 256 + (addr & 255);
      6, 7: nxt = addr;
      8: begin
        if (m_stk.size() == 0) begin
          m_udf = 1;
          nxt = m_last;
        end else begin
          nxt = m_stk.pop_front();
          m_last = nxt;
        end
      end
      default: nxt = m_pc;
    endcase
    if (op == 5 || op == 7) begin
      if (m_stk.size() == 2) begin
        m_ovf = 1;
        void'(m_stk.pop_back());
      end
      m_stk.push_front((m_pc + 1) % 1024);
    end
    m_pc = nxt;
  endtask

  // drive after a negedge, compare at the next negedge
  task automatic step(input int op, input int addr, input int alu, input bit pg, input string tag);
    op_i   = 4'(op);
    addr_i = 10'(addr);
    alu_i  = 8'(alu);
    page_i = pg;
    model(op, addr, alu, pg);
    @(negedge clk_i);
    compare(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    m_pc = 10'h3FF; m_last = 0; m_ovf = 0; m_udf = 0;
    repeat (3) @(negedge clk_i);
    compare("R1 during reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1 after release");

    // R2 sequential, skip, wrap
    step(1, 0, 0, 0, "R2 next wrap from 3FF");
    step(1, 0, 0, 0, "R2 next");
    step(2, 0, 0, 0, "R2 skip");
    step(6, 10'h3FE, 0, 0, "R5 long jump");
    step(2, 0, 0, 0, "R2 skip wrap");
    step(6, 10'h3FF, 0, 0, "R5 long jump");
    step(2, 0, 0, 0, "R2 skip wrap odd");

    // R3 PC write
    step(3, 10'h3FF, 8'hA5, 1, "R3 pc write page 1");
    step(3, 10'h3FF, 8'h3C, 0, "R3 pc write page 0");

    // R4 short jump / call
    step(4, 10'h277, 0, 0, "R4 short jump a9 from addr, page 0");
    step(4, 10'h144, 0, 1, "R4 short jump page 1");
    step(5, 10'h3EE, 0, 1, "R4 short call forces a9 0");
    step(8, 0, 0, 0, "R6 return from short call");

    // R5 long jump / call
    step(7, 10'h2A5, 0, 0, "R5 long call");
    step(8, 0, 0, 0, "R6 return from long call");

    // R7 two-level nesting
    step(7, 10'h100, 0, 0, "R7 call level 1");
    step(1, 0, 0, 0, "R7 next");
    step(5, 10'h020, 0, 1, "R7 call level 2");
    step(8, 0, 0, 0, "R7 return level 2");
    step(8, 0, 0, 0, "R7 return level 1");

    // R9 empty pops return last popped
    step(8, 0, 0, 0, "R9 empty return");
    step(1, 0, 0, 0, "R9 pulse cleared");
    step(8, 0, 0, 0, "R9 empty return again");

    // R8 third nested call drops oldest
    step(7, 10'h010, 0, 0, "R8 call 1");
    step(7, 10'h020, 0, 0, "R8 call 2");
    step(7, 10'h030, 0, 0, "R8 call 3 overflow");
    step(7, 10'h040, 0, 0, "R8 call 4 overflow");
    step(1, 0, 0, 0, "R8 pulse cleared");
    step(8, 0, 0, 0, "R8 return newest");
    step(8, 0, 0, 0, "R8 return second");
    step(8, 0, 0, 0, "R9 oldest was dropped");

    // R10 hold and unused codes
    step(7, 10'h155, 0, 0, "R10 setup call");
    for (int c = 9; c < 16; c++) step(c, 10'h3FF, 8'hFF, 1, "R10 unused code");
    step(0, 10'h3FF, 8'hFF, 1, "R10 hold");
    step(8, 0, 0, 0, "R10 stack untouched");
    step(8, 0, 0, 0, "R10 stack now empty");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom_range(0, 15);
      step(op, $urandom_range(0, 1023), $urandom_range(0, 255), 1'($urandom_range(0, 1)),
           "R6 mixed traffic");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule